// File: doc/BRIEF.md
# Register Renamer with Free Pool

This block is the rename stage of an out-of-order core. It maps a small set of architectural (logical) register names onto a larger set of physical registers. Each incoming instruction names two source registers and one destination. The block translates both sources through a speculative map. It then takes a fresh physical register from a pool of unused ones for the destination, and reports the physical register that the destination named until then. The instruction carries these three tags forward. Register values live only in the physical register file, which is outside this block, so retiring an instruction never moves data.

At retirement the surrounding logic presents the retiring instruction's destination, its new physical tag and its previous physical tag. The block points the committed map at the new tag and hands the previous tag back to the pool. When a flush squashes every speculative instruction, the speculative map is rebuilt from the committed map in one cycle. Every physical register taken by a squashed instruction goes back to the front of the pool, in the order it was taken. When the pool is empty, rename stalls.

Logical registers are numbered 0 to NUM_LOG-1 and physical registers 0 to NUM_PHYS-1. The defaults are 32 and 64.

Top module: `reg_renamer`

## Requirements
- R1: After reset, logical register i maps to physical register i. The pool holds physical registers NUM_LOG to NUM_PHYS-1 and hands them out in ascending order. After reset, `stall` is 0 and `out_valid` is 0.
- R2: Both sources are translated through the speculative map as it stood before this instruction's destination is updated. A source equal to the destination therefore gets the old mapping. The next instruction sees the new mapping.
- R3: An accepted instruction receives the tag at the front of the pool as `out_dst_phys`, and the destination's previous speculative mapping as `out_prev_phys`. The two always differ.
- R4: An instruction is accepted when `in_valid` is 1, `stall` is 0 and `flush` is 0. Its tags appear on the outputs with `out_valid` set one cycle later. Otherwise `out_valid` is 0 in the next cycle.
- R5: `stall` is 1 exactly when the pool is empty. A request made while stalled is ignored: it produces no output and takes no tag.
- R6: A commit appends `cmt_prev_phys` to the back of the pool, so that tag is handed out after every tag already in the pool.
- R7: A commit sets the committed mapping of `cmt_dst` to `cmt_new_phys`. This becomes visible to renames through the next flush.
- R8: A flush copies the committed map into the speculative map. It puts the squashed instructions' tags back at the front of the pool in their original order, and ignores any rename request in the same cycle.
- R9: A commit and a flush in the same cycle act as if the commit came first.
- R10: A rename and a commit in the same cycle both take effect. The tag that the commit returns goes behind any tag the rename could take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Rename request |
| in_src_a | input | 5 | First source logical register |
| in_src_b | input | 5 | Second source logical register |
| in_dst | input | 5 | Destination logical register |
| stall | output | 1 | Pool empty, request will not be accepted |
| out_valid | output | 1 | Renamed instruction present on the outputs |
| out_src_a_phys | output | 6 | Physical tag of first source |
| out_src_b_phys | output | 6 | Physical tag of second source |
| out_dst_phys | output | 6 | Newly taken physical tag for the destination |
| out_prev_phys | output | 6 | Destination's previous speculative tag |
| cmt_valid | input | 1 | Oldest in-flight instruction retires |
| cmt_dst | input | 5 | Its destination logical register |
| cmt_new_phys | input | 6 | Its allocated physical tag |
| cmt_prev_phys | input | 6 | Its previous physical tag, to be freed |
| flush | input | 1 | Squash all in-flight instructions |

## Verification
A corrupted speculative map entry shows up at the first later rename that reads that logical register as a source or a destination. A corrupted committed entry stays hidden until the next flush. After that flush, the first rename that reads the register shows it. A pool fault, such as a lost, duplicated or reordered tag or a wrong rollback point, changes the order of `out_dst_phys` values, or moves the cycle in which `stall` rises by at least one accepted rename. The bench therefore drains the pool to empty several times, mixes flushes and commits into those runs, and compares every output tag against a queue-based model.

// File: rtl/renamer_pkg.sv
package renamer_pkg;
  localparam int DEF_NUM_LOG  = 32;
  localparam int DEF_NUM_PHYS = 64;

  function automatic int ceil_log2(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction
endpackage

// File: rtl/rn_free_ring.sv
// Circular pool of free physical tags. Allocation pops at head, retirement
// pushes at tail. A third pointer trails head by the in-flight count; on a
// flush head snaps back to it, returning squashed tags in allocation order.
module rn_free_ring #(
  parameter int DEPTH = 32,
  parameter int PW    = 6,
  parameter int BASE  = 32,
  localparam int AW   = renamer_pkg::ceil_log2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          retire,
  input  logic [PW-1:0] retire_tag,
  input  logic          rollback,
  output logic [PW-1:0] head_tag,
  output logic [CW-1:0] avail
);
  logic [PW-1:0] slots [DEPTH];
  logic [CW-1:0] head_q, tail_q, keep_q;

  assign head_tag = slots[head_q[AW-1:0]];
  assign avail    = tail_q - head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= PW'(BASE + i);
      head_q <= '0;
      keep_q <= '0;
      tail_q <= CW'(DEPTH);
    end else begin
      if (retire) begin
        slots[tail_q[AW-1:0]] <= retire_tag;
        tail_q <= tail_q + 1'b1;
        keep_q <= keep_q + 1'b1;
      end
      if (rollback)
        head_q <= keep_q + CW'(retire);
      else if (pop)
        head_q <= head_q + 1'b1;
    end
  end
endmodule

// File: rtl/rn_map_table.sv
// Speculative and committed logical-to-physical maps held in flops so the
// whole committed map can be copied into the speculative one in one cycle.
module rn_map_table #(
  parameter int NL = 32,
  parameter int PW = 6,
  localparam int LW = renamer_pkg::ceil_log2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rd_a,
  input  logic [LW-1:0] rd_b,
  input  logic [LW-1:0] rd_d,
  output logic [PW-1:0] q_a,
  output logic [PW-1:0] q_b,
  output logic [PW-1:0] q_d,
  input  logic          spec_we,
  input  logic [LW-1:0] spec_idx,
  input  logic [PW-1:0] spec_tag,
  input  logic          arch_we,
  input  logic [LW-1:0] arch_idx,
  input  logic [PW-1:0] arch_tag,
  input  logic          restore
);
  logic [NL*PW-1:0] spec_flat;

  for (genvar i = 0; i < NL; i++) begin : g_ent
    logic [PW-1:0] spec_q, arch_q, arch_nxt;
    logic          arch_hit;

    assign arch_hit = arch_we && (arch_idx == LW'(i));
    assign arch_nxt = arch_hit ? arch_tag : arch_q;
    assign spec_flat[i*PW +: PW] = spec_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        spec_q <= PW'(i);
        arch_q <= PW'(i);
      end else begin
        arch_q <= arch_nxt;
        if (restore)
          spec_q <= arch_nxt;
        else if (spec_we && spec_idx == LW'(i))
          spec_q <= spec_tag;
      end
    end
  end

  assign q_a = spec_flat[rd_a*PW +: PW];
  assign q_b = spec_flat[rd_b*PW +: PW];
  assign q_d = spec_flat[rd_d*PW +: PW];
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int NUM_LOG  = renamer_pkg::DEF_NUM_LOG,
  parameter int NUM_PHYS = renamer_pkg::DEF_NUM_PHYS,
  localparam int LW   = renamer_pkg::ceil_log2(NUM_LOG),
  localparam int PW   = renamer_pkg::ceil_log2(NUM_PHYS),
  localparam int FREE = NUM_PHYS - NUM_LOG,
  localparam int CW   = renamer_pkg::ceil_log2(FREE) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [LW-1:0] in_src_a,
  input  logic [LW-1:0] in_src_b,
  input  logic [LW-1:0] in_dst,
  output logic          stall,
  output logic          out_valid,
  output logic [PW-1:0] out_src_a_phys,
  output logic [PW-1:0] out_src_b_phys,
  output logic [PW-1:0] out_dst_phys,
  output logic [PW-1:0] out_prev_phys,
  input  logic          cmt_valid,
  input  logic [LW-1:0] cmt_dst,
  input  logic [PW-1:0] cmt_new_phys,
  input  logic [PW-1:0] cmt_prev_phys,
  input  logic          flush
);
  logic [CW-1:0] free_cnt;
  logic [PW-1:0] fresh_tag, map_a, map_b, map_d;
  logic          accept;

  assign stall  = (free_cnt == '0);
  assign accept = in_valid && !stall && !flush;

  rn_free_ring #(.DEPTH(FREE), .PW(PW), .BASE(NUM_LOG)) u_pool (
    .clk(clk), .rst(rst),
    .pop(accept),
    .retire(cmt_valid), .retire_tag(cmt_prev_phys),
    .rollback(flush),
    .head_tag(fresh_tag), .avail(free_cnt)
  );

  rn_map_table #(.NL(NUM_LOG), .PW(PW)) u_maps (
    .clk(clk), .rst(rst),
    .rd_a(in_src_a), .rd_b(in_src_b), .rd_d(in_dst),
    .q_a(map_a), .q_b(map_b), .q_d(map_d),
    .spec_we(accept), .spec_idx(in_dst), .spec_tag(fresh_tag),
    .arch_we(cmt_valid), .arch_idx(cmt_dst), .arch_tag(cmt_new_phys),
    .restore(flush)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_src_a_phys <= '0;
      out_src_b_phys <= '0;
      out_dst_phys   <= '0;
      out_prev_phys  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src_a_phys <= map_a;
        out_src_b_phys <= map_b;
        out_dst_phys   <= fresh_tag;
        out_prev_phys  <= map_d;
      end
    end
  end
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int PW   = 6,
  parameter int CW   = 6,
  parameter int FREE = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          stall,
  input logic          flush,
  input logic          cmt_valid,
  input logic          out_valid,
  input logic [PW-1:0] out_dst_phys,
  input logic [PW-1:0] out_prev_phys,
  input logic [CW-1:0] free_cnt
);
  p_out_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !stall && !flush) |=> out_valid);

  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (stall && in_valid) |=> !out_valid);

  p_flush_kills_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  p_fresh_dst_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dst_phys != out_prev_phys));

  p_alloc_drains_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !stall && !flush && !cmt_valid) |=> (free_cnt == $past(free_cnt) - 1'b1));

  p_commit_returns_r6: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !flush && !(in_valid && !stall)) |=> (free_cnt == $past(free_cnt) + 1'b1));

  p_pool_bound_r6: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CW'(FREE));
endmodule

bind reg_renamer rn_checker #(.PW(PW), .CW(CW), .FREE(FREE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .stall(stall), .flush(flush),
  .cmt_valid(cmt_valid), .out_valid(out_valid), .out_dst_phys(out_dst_phys),
  .out_prev_phys(out_prev_phys), .free_cnt(free_cnt)
);

// File: tb/sim_reg_renamer.sv
`timescale 1ns/1ps
module sim_reg_renamer;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, cmt_valid, flush, stall, out_valid;
  logic [4:0] in_src_a, in_src_b, in_dst, cmt_dst;
  logic [5:0] cmt_new_phys, cmt_prev_phys;
  logic [5:0] out_src_a_phys, out_src_b_phys, out_dst_phys, out_prev_phys;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int spec_m [32];
  int arch_m [32];
  int free_q [$];
  int inf_dst [$];
  int inf_new [$];
  int inf_prev [$];

  always #10 clk = ~clk;

  reg_renamer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .stall(stall), .out_valid(out_valid),
    .out_src_a_phys(out_src_a_phys), .out_src_b_phys(out_src_b_phys),
    .out_dst_phys(out_dst_phys), .out_prev_phys(out_prev_phys),
    .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_new_phys(cmt_new_phys),
    .cmt_prev_phys(cmt_prev_phys), .flush(flush)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      spec_m[i] = i;
      arch_m[i] = i;
    end
    free_q.delete();
    for (int i = 32; i < 64; i++) free_q.push_back(i);
    inf_dst.delete(); inf_new.delete(); inf_prev.delete();
  endtask

  // One cycle: entered at a negedge, leaves at the next negedge.
  task automatic step(input bit v, input int a, input int b, input int d,
                      input bit c, input bit f, input string tag);
    bit acc, cm;
    int ea, eb, en, ep;
    check(stall == (free_q.size() == 0), "R5", {tag, " stall"}, stall, free_q.size() == 0);
    cm  = c && (inf_dst.size() > 0);
    acc = v && (free_q.size() > 0) && !f;
    in_valid = v; in_src_a = 5'(a); in_src_b = 5'(b); in_dst = 5'(d);
    flush = f; cmt_valid = cm;
    if (cm) begin
      cmt_dst = 5'(inf_dst[0]); cmt_new_phys = 6'(inf_new[0]); cmt_prev_phys = 6'(inf_prev[0]);
    end
    ea = spec_m[a]; eb = spec_m[b]; ep = spec_m[d]; en = 0;
    if (cm) begin
      arch_m[inf_dst[0]] = inf_new[0];
      free_q.push_back(inf_prev[0]);
      void'(inf_dst.pop_front()); void'(inf_new.pop_front()); void'(inf_prev.pop_front());
    end
    if (acc) begin
      en = free_q.pop_front();
      spec_m[d] = en;
      inf_dst.push_back(d); inf_new.push_back(en); inf_prev.push_back(ep);
    end
    if (f) begin
      for (int i = inf_new.size() - 1; i >= 0; i--) free_q.push_front(inf_new[i]);
      inf_dst.delete(); inf_new.delete(); inf_prev.delete();
      for (int i = 0; i < 32; i++) spec_m[i] = arch_m[i];
    end
    @(posedge clk); #1;
    in_valid = 0; cmt_valid = 0; flush = 0;
    check(out_valid == acc, "R4", {tag, " out_valid"}, out_valid, acc);
    if (acc && out_valid) begin
      check(out_src_a_phys == 6'(ea), tag, "src_a", out_src_a_phys, ea);
      check(out_src_b_phys == 6'(eb), tag, "src_b", out_src_b_phys, eb);
      check(out_dst_phys == 6'(en), "R3", {tag, " dst"}, out_dst_phys, en);
      check(out_prev_phys == 6'(ep), "R3", {tag, " prev"}, out_prev_phys, ep);
    end
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; in_valid = 0; cmt_valid = 0; flush = 0;
    in_src_a = 0; in_src_b = 0; in_dst = 0; cmt_dst = 0; cmt_new_phys = 0; cmt_prev_phys = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(stall == 0, "R1", "reset stall", stall, 0);
    check(out_valid == 0, "R1", "reset out_valid", out_valid, 0);

    // R1 / R2: reset mapping and source-before-destination ordering
    step(1, 1, 2, 1, 0, 0, "R1");
    step(1, 1, 3, 1, 0, 0, "R2");
    step(1, 5, 5, 5, 0, 0, "R2");
    // R5: drain the pool, then request while stalled
    while (free_q.size() > 0) step(1, 4, 7, 9, 0, 0, "R3");
    step(1, 2, 3, 4, 0, 0, "R5");
    step(1, 2, 3, 4, 0, 0, "R5");
    // R6 / R10: commit while stalled, then rename and commit together
    step(1, 1, 1, 1, 1, 0, "R6");
    step(1, 1, 2, 6, 1, 0, "R10");
    step(1, 6, 1, 2, 0, 0, "R10");
    // R7 / R8: commits, then flush restores committed view
    step(0, 0, 0, 0, 1, 0, "R7");
    step(1, 2, 3, 4, 0, 1, "R8");
    step(1, 1, 5, 1, 0, 0, "R7");
    step(1, 6, 9, 2, 0, 0, "R8");
    // R9: commit and flush in the same cycle
    step(1, 3, 3, 3, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 1, "R9");
    step(1, 1, 2, 1, 0, 0, "R9");

    for (int n = 0; n < 4000; n++) begin
      bit v, c, f;
      int slow;
      slow = ((n / 500) % 2 == 1) ? 6 : 2;
      v = ($urandom_range(3, 0) != 0);
      c = ($urandom_range(slow - 1, 0) == 0);
      f = ($urandom_range(59, 0) == 0);
      step(v, int'($urandom_range(31, 0)), int'($urandom_range(31, 0)),
           int'($urandom_range(31, 0)), c, f, "R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule